// File: doc/BRIEF.md
# Dual-Comparator Timer Compare Unit

A 10-bit up-counter that advances on an external count tick and compares its value against two programmed thresholds. Channel A holds a full 10-bit value. Channel P holds a 3-bit period code whose nonzero values sit on multiples of 128 counts. A clear-select control picks which channel's match returns the counter to zero. The same control also decides whether the period channel may report its matches. When the period code is zero and the period channel is the clear source, the counter runs freely and wraps from 1023 to 0, and each wrap raises an overflow flag.

A small byte-wide register bank gives the host control of the block. It holds the control bits, the channel A value (a low byte plus a two-bit upper part) and the period code. A fourth location is used to clear flags: writing 1 to a bit clears that flag. The three flags stay set until the host clears them, and they also appear directly on output pins. The counter value appears on its own output port. Only the plain compare-match mode is implemented. Any other value in the two mode fields parks the unit.

Top module: `cmp_timer`

## Requirements
- R1: After reset the counter is 0, all three flags are 0 and every register location reads 0.
- R2: Address 1 holds channel A bits 7..0. Address 2 holds channel A bits 9..8 in data bits 1..0 and reads 0 in bits 7..2. Address 3 holds the period code in bits 2..0 and reads 0 above them. Address 0 reads back control bits 5..0 and reads 0 in bits 7..6.
- R3: The unit is active only when the control run bit (bit 0) is 1 and both mode fields (bits 3..2 and bits 5..4) are 00. While it is inactive, the counter is forced to 0 and no flag is set.
- R4: When the unit is active, clear-select (control bit 1) is 0 and the period code p is nonzero, the counter counts 0..128*p. On the tick taken at 128*p it returns to 0, so each cycle lasts 128*p+1 ticks.
- R5: When the unit is active, clear-select is 0 and p is 0, the counter counts 0..1023. The tick taken at 1023 wraps it to 0 and sets the overflow flag (flag bit 2). A clear caused by a match at 1023 is not a wrap and does not set the overflow flag.
- R6: When the unit is active and clear-select is 1, the tick taken while the counter equals the channel A value returns the counter to 0.
- R7: The A flag (flag bit 0) is set by the tick taken while the counter equals the channel A value. This holds for either clear-select setting.
- R8: The P flag (flag bit 1) is set by the tick taken at 128*p when p is nonzero and clear-select is 0. It is never set while clear-select is 1, whatever the period and A values are.
- R9: Flags are sticky. Writing to address 4 clears each flag whose data bit is 1 and leaves the others unchanged. If a flag is set and cleared in the same cycle, the set wins.
- R10: The counter changes only on clock cycles in which the tick input is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Count enable, one cycle per count |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address for both write and read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| count | output | 10 | Current counter value |
| flag_a | output | 1 | Sticky channel A match flag |
| flag_p | output | 1 | Sticky period match flag |
| flag_ovf | output | 1 | Sticky overflow flag |

## Verification
A wrong clear source or a wrong period decode shows on `count` within one counting cycle. The expected residue of the tick count modulo the cycle length then no longer matches, so the error is visible after at most about a thousand ticks. A wrong flag-enable decision shows as a stuck or missing level on `flag_a`, `flag_p` or `flag_ovf` immediately after the tick that should (or should not) have raised it. A register-bank fault shows at once on `bus_rdata` or in the next counting cycle. The sweeps cover every period code, a range of channel A values under both clear selections, each non-compare mode value, and the same-cycle set and clear race.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;
  localparam int ADR_CTRL   = 0;
  localparam int ADR_CMP_LO = 1;
  localparam int ADR_CMP_HI = 2;
  localparam int ADR_PER    = 3;
  localparam int ADR_FLAGS  = 4;

  localparam int CTL_RUN    = 0;
  localparam int CTL_CLRSEL = 1;
  localparam int CTL_W      = 6;

  localparam int FLG_A      = 0;
  localparam int FLG_P      = 1;
  localparam int FLG_OVF    = 2;
  localparam int N_FLAGS    = 3;
endpackage

// File: rtl/cmp_timer_regs.sv
module cmp_timer_regs
  import cmp_timer_pkg::*;
#(
  parameter int CNT_W  = 10,
  parameter int PER_W  = 3,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [N_FLAGS-1:0]  flags,
  output logic [DATA_W-1:0]   rdata,
  output logic [CTL_W-1:0]    ctrl,
  output logic [CNT_W-1:0]    cmp_a,
  output logic [PER_W-1:0]    per,
  output logic [N_FLAGS-1:0]  flag_clr
);
  localparam int HI_W = CNT_W - DATA_W;

  logic sel_ctrl, sel_lo, sel_hi, sel_per, sel_flg;

  assign sel_ctrl = addr == ADDR_W'(ADR_CTRL);
  assign sel_lo   = addr == ADDR_W'(ADR_CMP_LO);
  assign sel_hi   = addr == ADDR_W'(ADR_CMP_HI);
  assign sel_per  = addr == ADDR_W'(ADR_PER);
  assign sel_flg  = addr == ADDR_W'(ADR_FLAGS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl  <= '0;
      cmp_a <= '0;
      per   <= '0;
    end else if (we) begin
      if (sel_ctrl) ctrl <= wdata[CTL_W-1:0];
      if (sel_lo)   cmp_a[DATA_W-1:0] <= wdata;
      if (sel_hi)   cmp_a[CNT_W-1:DATA_W] <= wdata[HI_W-1:0];
      if (sel_per)  per <= wdata[PER_W-1:0];
    end
  end

  assign flag_clr = (we && sel_flg) ? wdata[N_FLAGS-1:0] : '0;

  always_comb begin
    rdata = '0;
    if (sel_ctrl)     rdata = DATA_W'(ctrl);
    else if (sel_lo)  rdata = cmp_a[DATA_W-1:0];
    else if (sel_hi)  rdata = DATA_W'(cmp_a[CNT_W-1:DATA_W]);
    else if (sel_per) rdata = DATA_W'(per);
    else if (sel_flg) rdata = DATA_W'(flags);
  end

  AST_HI_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    sel_hi |-> (rdata[DATA_W-1:HI_W] == '0)); // R2
  AST_PER_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    sel_per |-> (rdata[DATA_W-1:PER_W] == '0)); // R2
endmodule

// File: rtl/cmp_timer_core.sv
module cmp_timer_core #(
  parameter int CNT_W = 10,
  parameter int PER_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             active,
  input  logic             clr_sel,
  input  logic [CNT_W-1:0] cmp_a,
  input  logic [PER_W-1:0] per,
  output logic [CNT_W-1:0] cnt,
  output logic             evt_a,
  output logic             evt_p,
  output logic             evt_ovf
);
  localparam int LOW_W = CNT_W - PER_W;

  function automatic logic [CNT_W-1:0] period_point(input logic [PER_W-1:0] p);
    return {p, {LOW_W{1'b0}}};
  endfunction

  logic hit_a, hit_p, clr_hit, step, wrap;

  assign hit_a   = cnt == cmp_a;
  assign hit_p   = (per != '0) && (cnt == period_point(per));
  assign clr_hit = clr_sel ? hit_a : hit_p;
  assign step    = active && tick;
  assign wrap    = (cnt == {CNT_W{1'b1}}) && !clr_hit;

  assign evt_a   = step && hit_a;
  assign evt_p   = step && hit_p && !clr_sel;
  assign evt_ovf = step && wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!active)    cnt <= '0;
    else if (tick)       cnt <= clr_hit ? '0 : cnt + 1'b1;
  end

  AST_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (cnt == '0)); // R3
  AST_TICK_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !tick && $past(active)) |=> $stable(cnt)); // R10
  AST_CLEAR_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (step && clr_hit) |=> (cnt == '0)); // R6
  AST_OVF_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    evt_ovf |=> (cnt == '0)); // R5
endmodule

// File: rtl/cmp_timer_flags.sv
module cmp_timer_flags #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_q
);
  for (genvar k = 0; k < N; k++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         flag_q[k] <= 1'b0;
      else if (set_i[k])  flag_q[k] <= 1'b1;
      else if (clr_i[k])  flag_q[k] <= 1'b0;
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[k] |=> flag_q[k]); // R9
    AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[k] && !set_i[k]) |=> !flag_q[k]); // R9
    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q[k] && !clr_i[k]) |=> flag_q[k]); // R9
  end
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
  import cmp_timer_pkg::*;
#(
  parameter int CNT_W  = 10,
  parameter int PER_W  = 3,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [CNT_W-1:0]  count,
  output logic              flag_a,
  output logic              flag_p,
  output logic              flag_ovf
);
  logic [CTL_W-1:0]   ctrl;
  logic [CNT_W-1:0]   cmp_a;
  logic [PER_W-1:0]   per;
  logic [N_FLAGS-1:0] flag_clr, flag_set, flags;
  logic               active, clr_sel;
  logic               evt_a, evt_p, evt_ovf;

  assign active  = ctrl[CTL_RUN] && (ctrl[3:2] == 2'b00) && (ctrl[5:4] == 2'b00);
  assign clr_sel = ctrl[CTL_CLRSEL];

  cmp_timer_regs #(.CNT_W(CNT_W), .PER_W(PER_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .flags(flags), .rdata(bus_rdata), .ctrl(ctrl), .cmp_a(cmp_a), .per(per),
    .flag_clr(flag_clr)
  );

  cmp_timer_core #(.CNT_W(CNT_W), .PER_W(PER_W)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .active(active), .clr_sel(clr_sel),
    .cmp_a(cmp_a), .per(per), .cnt(count),
    .evt_a(evt_a), .evt_p(evt_p), .evt_ovf(evt_ovf)
  );

  always_comb begin
    flag_set          = '0;
    flag_set[FLG_A]   = evt_a;
    flag_set[FLG_P]   = evt_p;
    flag_set[FLG_OVF] = evt_ovf;
  end

  cmp_timer_flags #(.N(N_FLAGS)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_i(flag_set), .clr_i(flag_clr), .flag_q(flags)
  );

  assign flag_a   = flags[FLG_A];
  assign flag_p   = flags[FLG_P];
  assign flag_ovf = flags[FLG_OVF];

  AST_NO_P_WHEN_A_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_p) |-> $past(!clr_sel)); // R8
  AST_IDLE_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !$rose(flag_a) && !$rose(flag_p) && !$rose(flag_ovf)); // R3
endmodule

// File: tb/test_cmp_timer.sv
module test_cmp_timer;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       bus_we = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [9:0] count;
  logic       flag_a, flag_p, flag_ovf;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmp_timer i_cmp_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .count(count),
    .flag_a(flag_a), .flag_p(flag_p), .flag_ovf(flag_ovf)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog: actual=%0d cycles expected<=%0d", cycles, WATCHDOG);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    @(negedge clk);
    bus_addr = a;
    #1 v = int'(bus_rdata);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick = 1'b1;
    end
    @(negedge clk);
    tick = 1'b0;
    #1;
  endtask

  // Program a fresh case: stop, clear flags, load compare values, start.
  task automatic setup(input bit csel, input int p, input int ca);
    wr(3'd0, 8'h00);
    wr(3'd4, 8'h07);
    wr(3'd1, 8'(ca & 255));
    wr(3'd2, 8'(ca >> 8));
    wr(3'd3, 8'(p));
    wr(3'd0, {6'b0, csel, 1'b1});
  endtask

  // Expected state after n ticks, computed from the requirements.
  task automatic run_case(input bit csel, input int p, input int ca, input int n);
    int len, e_cnt, e_a, e_p, e_o;
    setup(csel, p, ca);
    ticks(n);
    if (csel) begin
      len = ca + 1;
      e_a = (n >= len);
      e_p = 0;
      e_o = 0;
    end else begin
      len = (p != 0) ? 128 * p + 1 : 1024;
      e_a = (ca < len) && (n > ca);
      e_p = (p != 0) && (n >= len);
      e_o = (p == 0) && (n >= 1024);
    end
    e_cnt = n % len;
    chk(csel ? "R6 count" : (p != 0 ? "R4 count" : "R5 count"), int'(count), e_cnt);
    chk("R7 flag_a", int'(flag_a), e_a);
    chk("R8 flag_p", int'(flag_p), e_p);
    chk("R5 flag_ovf", int'(flag_ovf), e_o);
  endtask

  initial begin
    int v;
    int ca_list[5] = '{0, 1, 5, 200, 1023};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 count", int'(count), 0);
    chk("R1 flags", int'({flag_ovf, flag_p, flag_a}), 0);
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v);
      chk("R1 regs", v, 0);
    end

    // R2 readback masking
    wr(3'd2, 8'hFF); rd(3'd2, v); chk("R2 cmp hi", v, 8'h03);
    wr(3'd1, 8'hA5); rd(3'd1, v); chk("R2 cmp lo", v, 8'hA5);
    wr(3'd3, 8'hFF); rd(3'd3, v); chk("R2 per", v, 8'h07);
    wr(3'd0, 8'hFF); rd(3'd0, v); chk("R2 ctrl", v, 8'h3F);

    // R3 non-compare modes and run low park the unit
    for (int m = 1; m < 7; m++) begin
      logic [7:0] c;
      c = (m < 4) ? 8'((m << 2) | 1) : 8'(((m - 3) << 4) | 1);
      setup(1'b0, 1, 0);
      wr(3'd0, c);
      ticks(300);
      chk("R3 mode count", int'(count), 0);
      chk("R3 mode flags", int'({flag_ovf, flag_p, flag_a}), 0);
    end
    setup(1'b0, 1, 0);
    wr(3'd0, 8'h02);
    ticks(200);
    chk("R3 run low count", int'(count), 0);
    chk("R3 run low flags", int'({flag_ovf, flag_p, flag_a}), 0);

    // R4 every period code, before and after the clear point
    for (int p = 1; p < 8; p++) begin
      run_case(1'b0, p, 100, 128 * p);
      run_case(1'b0, p, 100, 128 * p + 1 + 50 * p);
    end
    run_case(1'b0, 1, 300, 700);   // A beyond period never matches

    // R5 free run and overflow
    run_case(1'b0, 0, 600, 1023);
    run_case(1'b0, 0, 600, 1034);

    // R6 / R8 clear on A, period flag suppressed
    foreach (ca_list[i]) begin
      run_case(1'b1, 1, ca_list[i], 2 * (ca_list[i] + 1) + 3);
      run_case(1'b1, 7, ca_list[i], ca_list[i]);
    end

    // R9 set wins over same-cycle clear
    setup(1'b1, 0, 3);
    ticks(3);
    chk("R9 pre count", int'(count), 3);
    @(negedge clk);
    tick = 1'b1; bus_we = 1'b1; bus_addr = 3'd4; bus_wdata = 8'h01;
    @(negedge clk);
    tick = 1'b0; bus_we = 1'b0;
    #1;
    chk("R9 set wins", int'(flag_a), 1);
    chk("R6 cleared", int'(count), 0);
    wr(3'd4, 8'h01); #1;
    chk("R9 w1 clears", int'(flag_a), 0);
    ticks(4);
    chk("R9 reset again", int'(flag_a), 1);
    wr(3'd4, 8'h06); #1;
    chk("R9 other bits keep", int'(flag_a), 1);
    wr(3'd4, 8'h00); #1;
    chk("R9 zero write", int'(flag_a), 1);
    rd(3'd4, v);
    chk("R9 flag readback", v, 1);

    // R10 counting only on tick cycles
    setup(1'b0, 0, 1000);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
    #1;
    chk("R10 gapped ticks", int'(count), 40);
    repeat (25) @(negedge clk);
    #1;
    chk("R10 idle hold", int'(count), 40);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule